// File: doc/BRIEF.md
# Head Stepping and Seek Sequencer

This block moves a disk drive's read/write head. It carries out five positioning commands: return to track zero, seek to a target track, and three single-step forms (repeat the last direction, step inward, step outward). It drives a step pulse and a direction line toward the drive. It keeps an 8-bit register holding the track under the head, and it watches a track-zero sense input. A 2-bit field in each command picks the interval between step pulses. A build parameter picks one of two interval tables.

A seek compares the track register with the target and steps one track at a time until they match. Return-to-zero presets the track register to 255, takes 0 as the target and runs the same seek loop. It stops early when track zero is sensed and gives up after 255 pulses. When a command asks for verification, a head-settling wait follows the last step. The block then raises a request to an external ID-checking stage and takes that stage's pass/fail answer as its seek-error result. A busy flag covers each command. A one-cycle done strobe ends it. An abort input stops the command at the next internal state boundary.

Top module: `hs_stepper`

## Requirements
- R1: After reset, step, dir, busy, done, seek_err and vfy_req are 0 and track is 0.
- R2: Seek (cmd_op 1) steps toward `target`. It drives dir high for inward steps, where track goes up by 1 per pulse, and low for outward steps, where track goes down by 1 per pulse. It stops with track equal to target. A target equal to track gives no pulse.
- R3: Each step pulse is high for 4 µs when `fm_mode` is 0 at command start, and for 8 µs when it is 1.
- R4: The time from one step rising edge to the next is set by `cmd_rate`. With FAST_STEP=0, codes 0..3 select 6, 12, 20 and 30 ms. With FAST_STEP=1, they select 2, 3, 5 and 6 ms.
- R5: dir has held its value for at least 24 µs when the first pulse of a command rises. dir does not change while step is high.
- R6: Restore (cmd_op 0) ends with track 0. If trk0 is already high at the start, no pulse is issued. Otherwise it steps outward until trk0 is high.
- R7: If trk0 is still low after 255 restore pulses, restore stops with track 0 and issues no verify request. seek_err is then set only if `cmd_vfy` was 1.
- R8: Step (2), step-in (3) and step-out (4) each issue exactly one pulse. Step keeps the previous dir, step-in drives dir 1 and step-out drives dir 0. track changes by one only when `cmd_upd` is 1.
- R9: A command that would step outward while trk0 is high issues no pulse and loads track with 0.
- R10: With `cmd_vfy`=1, vfy_req rises no earlier than 30 ms after the last step pulse falls. It stays high until vfy_done. At vfy_done, seek_err takes the inverse of vfy_ok.
- R11: busy is high from command acceptance until done. done is a one-cycle strobe, given in the cycle busy falls. seek_err is cleared when a command is accepted.
- R12: An abort during a command ends it at the next state boundary with done. No step pulse follows the one in progress.
- R13: trk_wr loads track from trk_wdata only while busy is 0. Command codes 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command start strobe, taken while idle |
| cmd_op | input | 3 | 0 restore, 1 seek, 2 step, 3 step-in, 4 step-out |
| cmd_upd | input | 1 | Single-step commands update the track register |
| cmd_vfy | input | 1 | Settle, then request verification |
| cmd_rate | input | 2 | Step interval code |
| fm_mode | input | 1 | 1 selects the long step pulse |
| target | input | 8 | Seek target track |
| trk_wr | input | 1 | Track register load strobe |
| trk_wdata | input | 8 | Track register load value |
| trk0 | input | 1 | Head is at track zero (active high) |
| abort | input | 1 | Stop current command |
| vfy_done | input | 1 | Verify stage finished |
| vfy_ok | input | 1 | Verify stage result, 1 is pass |
| step | output | 1 | Step pulse to drive |
| dir | output | 1 | 1 inward, 0 outward |
| track | output | 8 | Track register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle command end strobe |
| seek_err | output | 1 | Seek error result |
| vfy_req | output | 1 | Request to external verify stage |

## Verification
Seeks run inward and outward from a loaded track, with different rate codes and both pulse widths. Measuring the step period and pulse width separates the rate table from the pulse-width selection. An equal-target seek shows that no pulse is issued. Restore runs once with the head away from zero, once already at zero and twice with a track-zero line that never asserts. These separate the early stop from the 255-pulse limit, and the limit with verify on from the limit with verify off. A sequence of single steps with and without the update flag separates direction memory from track counting. The abort, busy-time track write and invalid-code cases confirm that nothing moves after the stop point.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    OP_RESTORE  = 3'd0,
    OP_SEEK     = 3'd1,
    OP_STEP     = 3'd2,
    OP_STEP_IN  = 3'd3,
    OP_STEP_OUT = 3'd4
  } hs_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DIRSET, S_PULSE, S_RATE, S_SETTLE, S_VFY
  } hs_state_e;

  typedef struct packed {
    hs_op_e     op;
    logic       upd;
    logic       vfy;
    logic [1:0] rate;
    logic       fm;
  } hs_cmd_t;
endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (load)              cnt_n = val;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
    else                   cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/hs_rate_map.sv
module hs_rate_map #(
  parameter bit FAST_STEP = 1'b0
) (
  input  logic [1:0] sel,
  output logic [4:0] ms
);
  generate
    if (FAST_STEP) begin : g_fast
      always_comb begin
        case (sel)
          2'd0:    ms = 5'd2;
          2'd1:    ms = 5'd3;
          2'd2:    ms = 5'd5;
          default: ms = 5'd6;
        endcase
      end
    end else begin : g_std
      always_comb begin
        case (sel)
          2'd0:    ms = 5'd6;
          2'd1:    ms = 5'd12;
          2'd2:    ms = 5'd20;
          default: ms = 5'd30;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl import hs_pkg::*; #(
  parameter int CLK_PER_US = 8,
  parameter int US_PER_MS  = 1000,
  parameter int TW         = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_upd,
  input  logic          cmd_vfy,
  input  logic [1:0]    cmd_rate,
  input  logic          fm_mode,
  input  logic [7:0]    target,
  input  logic          trk_wr,
  input  logic [7:0]    trk_wdata,
  input  logic          trk0,
  input  logic          abort,
  input  logic          vfy_done,
  input  logic          vfy_ok,
  input  logic [4:0]    rate_ms,
  input  logic          tmr_exp,
  output logic [1:0]    rate_sel,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          step,
  output logic          dir,
  output logic [7:0]    track,
  output logic          busy,
  output logic          done,
  output logic          seek_err,
  output logic          vfy_req
);
  localparam int MS_CYC  = US_PER_MS * CLK_PER_US;
  localparam int PUL_MFM = 4 * CLK_PER_US;
  localparam int PUL_FM  = 8 * CLK_PER_US;
  localparam int DIR_CYC = 24 * CLK_PER_US;
  localparam int SET_CYC = 30 * MS_CYC;

  hs_state_e st, st_n;
  hs_cmd_t   cmd_q, cmd_n;
  logic [7:0] tgt_q, tgt_n, trk_q, trk_n, cnt_q, cnt_n;
  logic dir_q, dir_n, err_q, err_n, abt_q, abt_n, done_q, done_n;
  logic cmd_take, seek_type, go_step, go_fin, want_in;
  int   pulse_cyc, rate_cyc;

  assign cmd_take  = (st == S_IDLE) && cmd_valid && (cmd_op <= 3'd4);
  assign seek_type = (cmd_q.op == OP_RESTORE) || (cmd_q.op == OP_SEEK);
  assign pulse_cyc = cmd_q.fm ? PUL_FM : PUL_MFM;
  assign rate_cyc  = int'(rate_ms) * MS_CYC;
  assign rate_sel  = cmd_q.rate;

  always_comb begin
    cmd_n.op   = hs_op_e'(cmd_op);
    cmd_n.upd  = cmd_upd;
    cmd_n.vfy  = cmd_vfy;
    cmd_n.rate = cmd_rate;
    cmd_n.fm   = fm_mode;
  end

  always_comb begin
    st_n = st; tgt_n = tgt_q; trk_n = trk_q; dir_n = dir_q;
    cnt_n = cnt_q; err_n = err_q; done_n = 1'b0;
    tmr_load = 1'b0; tmr_val = '0;
    go_step = 1'b0; go_fin = 1'b0; want_in = 1'b0;
    case (st)
      S_IDLE: begin
        if (trk_wr) trk_n = trk_wdata;
        if (cmd_take) begin
          st_n = S_CHECK; cnt_n = '0; err_n = 1'b0;
          case (cmd_op)
            3'd0: begin trk_n = 8'hFF; tgt_n = 8'h00; end
            3'd1: tgt_n = target;
            3'd3: dir_n = 1'b1;
            3'd4: dir_n = 1'b0;
            default: ;
          endcase
        end
      end
      S_CHECK: begin
        want_in = tgt_q > trk_q;
        if (abt_q) begin
          st_n = S_IDLE; done_n = 1'b1;
        end else if (seek_type) begin
          if (cmd_q.op == OP_RESTORE && trk0) begin
            trk_n = 8'h00; go_fin = 1'b1;
          end else if (cmd_q.op == OP_RESTORE && cnt_q == 8'hFF) begin
            err_n = cmd_q.vfy; st_n = S_IDLE; done_n = 1'b1;
          end else if (trk_q == tgt_q) begin
            go_fin = 1'b1;
          end else if (!want_in && trk0) begin
            trk_n = 8'h00; go_fin = 1'b1;
          end else begin
            dir_n = want_in; go_step = 1'b1;
          end
        end else if (!dir_q && trk0) begin
          trk_n = 8'h00; go_fin = 1'b1;
        end else begin
          go_step = 1'b1;
        end
      end
      S_DIRSET: if (tmr_exp) begin
        if (abt_q) begin st_n = S_IDLE; done_n = 1'b1; end
        else begin st_n = S_PULSE; tmr_load = 1'b1; tmr_val = TW'(pulse_cyc - 1); end
      end
      S_PULSE: if (tmr_exp) begin
        if (seek_type || cmd_q.upd) trk_n = dir_q ? trk_q + 8'd1 : trk_q - 8'd1;
        if (cnt_q != 8'hFF) cnt_n = cnt_q + 8'd1;
        if (abt_q) begin st_n = S_IDLE; done_n = 1'b1; end
        else begin st_n = S_RATE; tmr_load = 1'b1; tmr_val = TW'(rate_cyc - pulse_cyc - 2); end
      end
      S_RATE: if (tmr_exp) begin
        if (abt_q)          begin st_n = S_IDLE; done_n = 1'b1; end
        else if (seek_type) st_n = S_CHECK;
        else                go_fin = 1'b1;
      end
      S_SETTLE: if (tmr_exp) begin
        if (abt_q) begin st_n = S_IDLE; done_n = 1'b1; end
        else       st_n = S_VFY;
      end
      S_VFY: begin
        if (abt_q) begin
          st_n = S_IDLE; done_n = 1'b1;
        end else if (vfy_done) begin
          err_n = !vfy_ok; st_n = S_IDLE; done_n = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (go_step) begin
      tmr_load = 1'b1;
      if (cnt_q == '0) begin st_n = S_DIRSET; tmr_val = TW'(DIR_CYC - 1); end
      else             begin st_n = S_PULSE;  tmr_val = TW'(pulse_cyc - 1); end
    end
    if (go_fin) begin
      if (cmd_q.vfy) begin st_n = S_SETTLE; tmr_load = 1'b1; tmr_val = TW'(SET_CYC - 1); end
      else           begin st_n = S_IDLE; done_n = 1'b1; end
    end
    abt_n = (st != S_IDLE) && (st_n != S_IDLE) && (abt_q || abort);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_q <= '0; tgt_q <= '0; trk_q <= '0; cnt_q <= '0;
      dir_q <= 1'b0; err_q <= 1'b0; abt_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st <= st_n;
      if (cmd_take) cmd_q <= cmd_n;
      tgt_q <= tgt_n; trk_q <= trk_n; cnt_q <= cnt_n;
      dir_q <= dir_n; err_q <= err_n; abt_q <= abt_n; done_q <= done_n;
    end
  end

  assign step     = (st == S_PULSE);
  assign dir      = dir_q;
  assign track    = trk_q;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign seek_err = err_q;
  assign vfy_req  = (st == S_VFY);
endmodule

// File: rtl/hs_stepper.sv
module hs_stepper #(
  parameter int CLK_PER_US = 8,
  parameter int US_PER_MS  = 1000,
  parameter bit FAST_STEP  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       cmd_upd,
  input  logic       cmd_vfy,
  input  logic [1:0] cmd_rate,
  input  logic       fm_mode,
  input  logic [7:0] target,
  input  logic       trk_wr,
  input  logic [7:0] trk_wdata,
  input  logic       trk0,
  input  logic       abort,
  input  logic       vfy_done,
  input  logic       vfy_ok,
  output logic       step,
  output logic       dir,
  output logic [7:0] track,
  output logic       busy,
  output logic       done,
  output logic       seek_err,
  output logic       vfy_req
);
  localparam int MAX_CYC = 30 * US_PER_MS * CLK_PER_US;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic          rst_m, rst_s;
  logic [1:0]    rate_sel;
  logic [4:0]    rate_ms;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_m <= 1'b0; rst_s <= 1'b0; end
    else        begin rst_m <= 1'b1; rst_s <= rst_m; end
  end

  hs_rate_map #(.FAST_STEP(FAST_STEP)) u_rate (.sel(rate_sel), .ms(rate_ms));

  hs_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_s), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
  );

  hs_ctrl #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_upd(cmd_upd), .cmd_vfy(cmd_vfy), .cmd_rate(cmd_rate), .fm_mode(fm_mode),
    .target(target), .trk_wr(trk_wr), .trk_wdata(trk_wdata), .trk0(trk0),
    .abort(abort), .vfy_done(vfy_done), .vfy_ok(vfy_ok), .rate_ms(rate_ms),
    .tmr_exp(tmr_exp), .rate_sel(rate_sel), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .step(step), .dir(dir), .track(track), .busy(busy), .done(done),
    .seek_err(seek_err), .vfy_req(vfy_req)
  );
endmodule

// File: rtl/hs_stepper_chk.sv
module hs_stepper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       trk_wr,
  input logic       step,
  input logic       dir,
  input logic [7:0] track,
  input logic       busy,
  input logic       done,
  input logic       seek_err,
  input logic       vfy_req
);
  // R5: direction held while the pulse is high
  a_r5_dir_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $stable(dir));

  // R11: done strobe only as busy ends, and lasts one cycle
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_err_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !seek_err);

  // R12: no step pulse outside a command
  a_r12_step_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);

  // R10: verify request only inside a command and never during a pulse
  a_r10_vfy_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_req |-> (busy && !step));

  // R13: idle track register moves only by a load
  a_r13_track_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trk_wr && !cmd_valid) |=> $stable(track));
endmodule

bind hs_stepper hs_stepper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .trk_wr(trk_wr),
  .step(step), .dir(dir), .track(track), .busy(busy), .done(done),
  .seek_err(seek_err), .vfy_req(vfy_req)
);

// File: tb/sim_hs_stepper.sv
`timescale 1ns/1ps
module sim_hs_stepper;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_upd = 0, cmd_vfy = 0, fm_mode = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_rate = 0;
  logic [7:0] target = 0, trk_wdata = 0;
  logic trk_wr = 0, trk0 = 0, abort = 0, vfy_done = 0, vfy_ok = 1;
  logic step, dir, busy, done, seek_err, vfy_req;
  logic [7:0] track;

  int checks = 0, errors = 0;
  int head_pos = 0; bit stuck = 0;
  int pulses = 0, last_w = 0, cur_w = 0, last_per = 0, since_rise = 0;
  int since_fall = 0, gap = 0, dir_age = 0, first_age = 0, vfy_cnt = 0;
  bit vfy_seen = 0, prev_step = 0, prev_vfy = 0, prev_dir = 0;

  always #10 clk = ~clk;

  hs_stepper #(.CLK_PER_US(1), .US_PER_MS(10), .FAST_STEP(1'b1)) u0 (.*);

  always @(negedge clk) begin
    if (dir != prev_dir) dir_age = 0; else dir_age++;
    if (step && !prev_step) begin
      if (pulses == 0) first_age = dir_age;
      last_per = since_rise + 1; since_rise = 0; pulses++;
      if (dir) head_pos++; else if (head_pos > 0) head_pos--;
    end else since_rise++;
    if (step) cur_w++;
    else if (prev_step) begin last_w = cur_w; cur_w = 0; since_fall = 0; end
    else since_fall++;
    if (vfy_req && !prev_vfy) begin vfy_seen = 1; gap = since_fall; end
    vfy_done = vfy_req && (vfy_cnt == 3);
    vfy_cnt  = vfy_req ? vfy_cnt + 1 : 0;
    trk0 = (head_pos == 0) && !stuck;
    prev_step = step; prev_vfy = vfy_req; prev_dir = dir;
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic clear_mon(); pulses = 0; vfy_seen = 0; last_w = 0; last_per = 0; endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 40000) begin tick(); n++; end
    chk(done === 1'b1 && busy === 1'b0, "R11 done with busy low", busy, 0);
    tick();
    chk(done === 1'b0, "R11 done is one cycle", done, 0);
  endtask

  task automatic issue(input logic [2:0] op, input logic upd, input logic vfy,
                       input logic [1:0] rate, input logic fm, input logic [7:0] tg);
    clear_mon();
    cmd_op = op; cmd_upd = upd; cmd_vfy = vfy; cmd_rate = rate; fm_mode = fm; target = tg;
    cmd_valid = 1; tick(); cmd_valid = 0;
  endtask

  task automatic load_trk(input logic [7:0] v);
    trk_wdata = v; trk_wr = 1; tick(); trk_wr = 0; tick();
  endtask

  task automatic t_reset();
    chk(step === 0 && busy === 0 && done === 0 && seek_err === 0 && vfy_req === 0,
        "R1 control outputs", {step, busy, done, seek_err, vfy_req}, 0);
    chk(track === 8'd0 && dir === 0, "R1 track and dir", track, 0);
  endtask

  task automatic t_seek_in();
    head_pos = 10; load_trk(8'd10);
    chk(track === 8'd10, "R13 idle track load", track, 10);
    issue(3'd1, 0, 0, 2'd0, 1'b0, 8'd14); wait_done();
    chk(pulses == 4 && track === 8'd14, "R2 seek inward pulses", pulses, 4);
    chk(dir === 1'b1, "R2 inward dir", dir, 1);
    chk(last_w == 4, "R3 MFM pulse width", last_w, 4);
    chk(last_per == 20, "R4 rate code 0 fast table", last_per, 20);
    chk(first_age >= 24, "R5 dir setup before first pulse", first_age, 24);
  endtask

  task automatic t_seek_out();
    issue(3'd1, 0, 0, 2'd3, 1'b1, 8'd11); wait_done();
    chk(pulses == 3 && track === 8'd11, "R2 seek outward", pulses, 3);
    chk(dir === 1'b0, "R2 outward dir", dir, 0);
    chk(last_w == 8, "R3 FM pulse width", last_w, 8);
    chk(last_per == 60, "R4 rate code 3 fast table", last_per, 60);
    issue(3'd1, 0, 0, 2'd0, 1'b0, 8'd11); wait_done();
    chk(pulses == 0 && track === 8'd11, "R2 equal target no pulse", pulses, 0);
  endtask

  task automatic t_restore();
    issue(3'd0, 0, 0, 2'd1, 1'b0, 8'd77); wait_done();
    chk(pulses == 11 && track === 8'd0, "R6 restore steps to zero", pulses, 11);
    chk(last_per == 30, "R4 rate code 1 fast table", last_per, 30);
    load_trk(8'd5);
    issue(3'd0, 0, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 0 && track === 8'd0, "R6 restore at zero", pulses, 0);
  endtask

  task automatic t_single();
    issue(3'd3, 1, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 1 && track === 8'd1 && dir === 1, "R8 step-in updates", track, 1);
    issue(3'd2, 0, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 1 && dir === 1 && track === 8'd1, "R8 step keeps dir, no update", track, 1);
    issue(3'd4, 1, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 1 && dir === 0 && track === 8'd0, "R8 step-out updates", track, 0);
    issue(3'd4, 1, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 1 && track === 8'hFF, "R8 step-out wraps count", track, 255);
    issue(3'd4, 1, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 0 && track === 8'd0, "R9 out at track zero", track, 0);
  endtask

  task automatic t_verify();
    vfy_ok = 1;
    issue(3'd1, 0, 1, 2'd0, 1'b0, 8'd2); wait_done();
    chk(vfy_seen && gap >= 300, "R10 settle before verify", gap, 300);
    chk(seek_err === 0 && track === 8'd2, "R10 verify pass", seek_err, 0);
    vfy_ok = 0;
    issue(3'd1, 0, 1, 2'd0, 1'b0, 8'd3); wait_done();
    chk(seek_err === 1, "R10 verify fail sets error", seek_err, 1);
    vfy_ok = 1;
    issue(3'd1, 0, 0, 2'd0, 1'b0, 8'd3); wait_done();
    chk(seek_err === 0, "R11 error cleared by new command", seek_err, 0);
  endtask

  task automatic t_limit();
    stuck = 1; head_pos = 1000;
    issue(3'd0, 0, 1, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 255 && track === 8'd0, "R7 limit pulses", pulses, 255);
    chk(seek_err === 1 && !vfy_seen, "R7 error with verify, no request", seek_err, 1);
    issue(3'd0, 0, 0, 2'd0, 1'b0, 8'd0); wait_done();
    chk(pulses == 255 && seek_err === 0, "R7 no error without verify", seek_err, 0);
    stuck = 0; head_pos = 0;
  endtask

  task automatic t_abort();
    int p, n;
    load_trk(8'd0);
    issue(3'd1, 0, 0, 2'd0, 1'b0, 8'd50);
    n = 0;
    while (pulses < 3 && n < 2000) begin tick(); n++; end
    abort = 1; tick(); abort = 0;
    wait_done();
    p = pulses;
    repeat (100) tick();
    chk(pulses == p && p <= 4 && busy === 0, "R12 abort stops stepping", pulses, p);
    chk(track === 8'(p), "R12 track matches issued pulses", track, p);
  endtask

  task automatic t_ignore();
    head_pos = 0; load_trk(8'd0);
    issue(3'd1, 0, 0, 2'd0, 1'b0, 8'd3);
    repeat (5) tick();
    trk_wdata = 8'd99; trk_wr = 1; tick(); trk_wr = 0;
    wait_done();
    chk(track === 8'd3, "R13 load ignored while busy", track, 3);
    cmd_op = 3'd5; cmd_valid = 1; tick(); cmd_valid = 0;
    repeat (3) tick();
    chk(busy === 0 && track === 8'd3, "R13 invalid code ignored", busy, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_seek_in();
    t_seek_out();
    t_restore();
    t_single();
    t_verify();
    t_limit();
    t_abort();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule